// File: doc/BRIEF.md
# Strobe-Selectable 7:1 Display Link Serializer

This block turns one 28-bit pixel word per pixel clock into four serial data lanes. Each lane sends seven bits per pixel clock. A fifth lane sends a forwarded clock that is phase-locked to the data, so a receiver can find the word boundary. The word holds 24 colour bits (red in bits 7:0, green in bits 15:8, blue in bits 23:16), line sync in bit 24, frame sync in bit 25, data enable in bit 26, and a spare control bit in bit 27.

The parallel word is sampled once per pixel clock. A static select input picks whether sampling happens on the rising or the falling pixel clock edge. The bit clock comes from outside the block, already locked at exactly seven times the pixel rate; the analog drivers and the PLL are not part of this block. An active-low power-down input drops the output-enable that the pad drivers use to tri-state the lanes.

A pixel cycle is the seven bit-clock periods that follow a rising edge of `pix_clk`. Rising edges of `pix_clk` coincide with rising edges of `bit_clk`. Slot s is the s-th bit period of a pixel cycle, counting from 0.

Top module: `dlink_ser7`

## Requirements
- R1: In slot s of a pixel cycle, data lane k carries bit 7k+s of the word that is serialized in that cycle. So bit 7k goes first and bit 7k+6 goes last.
- R2: The forwarded clock lane is high in slots 0 to 3 and low in slots 4 to 6 of every pixel cycle, so its rising edge marks slot 0.
- R3: When `strobe_rise` is 1, the word present at the rising `pix_clk` edge that starts pixel cycle c is serialized in cycle c+1.
- R4: When `strobe_rise` is 0, the word present at the falling `pix_clk` edge inside pixel cycle c is serialized in cycle c+1. Value 0 selects falling-edge capture, so a pulled-down select pin gives falling-edge capture.
- R5: While `pwdn_n` is 0, `ser_oe` is 0 from the next `bit_clk` rising edge on.
- R6: Whenever `ser_oe` is 0, every data lane and the clock lane are driven 0.
- R7: After `pwdn_n` returns to 1, `ser_oe` is 1 from the next `bit_clk` rising edge. The first pixel cycle that starts after the release carries the regular word of R3/R4, as long as the release does not fall in slot 6. So valid data resumes within two pixel clocks.
- R8: While `rst_n` is 0, `ser_oe`, all data lanes and the clock lane are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pix_clk | input | 1 | Pixel clock. Its rising edges are aligned to `bit_clk` rising edges. |
| bit_clk | input | 1 | Serial bit clock, locked at seven times `pix_clk`. |
| rst_n | input | 1 | Asynchronous active-low reset. |
| strobe_rise | input | 1 | Static capture edge select: 1 selects rising, 0 selects falling. |
| pwdn_n | input | 1 | Active-low power-down, synchronous to `bit_clk`. |
| pix_word | input | 28 | Parallel pixel word: colour, syncs, data enable and spare bit. |
| ser_data | output | 4 | Serial data lanes, one bit per lane per `bit_clk` period. |
| ser_clk | output | 1 | Forwarded clock lane. |
| ser_oe | output | 1 | Output enable for all five lanes. |

## Verification
A word sampled at the rising edge that opens pixel cycle c leaves in cycle c+1, between seven and thirteen bit periods later. A word sampled at the falling edge inside cycle c leaves in the next cycle. The output-enable follows power-down one bit-clock edge later. The bench samples all lanes at falling `bit_clk` edges and collects the seven slots of a pixel cycle. At slot 6 it compares the result with the word it drove one cycle earlier (falling mode) or two cycles earlier (rising mode); the mode used is the one selected during the previous cycle. Enable and quiet-lane checks start only at the first falling edge after a power-down change. Word checks skip the cycles that power-down interrupts and start again with the first whole cycle after release.

// File: rtl/dlink_ser7_pkg.sv
package dlink_ser7_pkg;

    // Default geometry: four data lanes, seven slots per pixel clock.
    localparam int unsigned DEF_LANES = 4;
    localparam int unsigned DEF_SLOTS = 7;

    // The forwarded clock is high for the first half of the slots (rounded up)
    // so that its single rising edge lines up with slot 0.
    function automatic int clk_high_slots(input int slots);
        return (slots + 1) / 2;
    endfunction

endpackage

// File: rtl/dlink_ser7_capture.sv
// Pixel-clock-domain capture of the parallel word on both edges.
module dlink_ser7_capture #(
    parameter int unsigned WORD_W = 28
) (
    input  logic              pix_clk,
    input  logic              rst_n,
    input  logic              strobe_rise,
    input  logic [WORD_W-1:0] pix_word,
    output logic [WORD_W-1:0] cap_word
);

    typedef logic [WORD_W-1:0] word_t;

    word_t rise_d, rise_q;
    word_t fall_d, fall_q;

    always_comb begin
        rise_d = pix_word;
        fall_d = pix_word;
    end

    always_ff @(posedge pix_clk or negedge rst_n) begin
        if (!rst_n) rise_q <= '0;
        else        rise_q <= rise_d;
    end

    always_ff @(negedge pix_clk or negedge rst_n) begin
        if (!rst_n) fall_q <= '0;
        else        fall_q <= fall_d;
    end

    // Static selection between the two captured copies: no clock muxing.
    assign cap_word = strobe_rise ? rise_q : fall_q;

endmodule

// File: rtl/dlink_ser7_slot_timer.sv
// Bit-clock-domain slot counter, realigned on every pixel clock rising edge.
module dlink_ser7_slot_timer #(
    parameter int unsigned SLOTS  = 7,
    localparam int unsigned SLOT_W = $clog2(SLOTS)
) (
    input  logic              bit_clk,
    input  logic              rst_n,
    input  logic              pix_clk_smp,
    output logic [SLOT_W-1:0] slot_o,
    output logic              last_o
);

    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS - 1);
    localparam logic [SLOT_W-1:0] ONE_SLOT  = SLOT_W'(1);

    typedef struct packed {
        logic              pix_seen;
        logic [SLOT_W-1:0] slot;
    } tmr_t;

    tmr_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        st_d.pix_seen = pix_clk_smp;
        if (pix_clk_smp && !st_q.pix_seen) begin
            // First bit edge inside a new pixel cycle: slot 0 has just run.
            st_d.slot = ONE_SLOT;
        end else if (st_q.slot == LAST_SLOT) begin
            st_d.slot = '0;
        end else begin
            st_d.slot = st_q.slot + ONE_SLOT;
        end
    end

    always_ff @(posedge bit_clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign slot_o = st_q.slot;
    assign last_o = (st_q.slot == LAST_SLOT);

endmodule

// File: rtl/dlink_ser7_lanes.sv
// Two-stage transfer into the bit domain, then per-lane slot selection.
module dlink_ser7_lanes #(
    parameter int unsigned LANES  = 4,
    parameter int unsigned SLOTS  = 7,
    localparam int unsigned WORD_W = LANES * SLOTS,
    localparam int unsigned SLOT_W = $clog2(SLOTS)
) (
    input  logic              bit_clk,
    input  logic              rst_n,
    input  logic              pwdn_n,
    input  logic [WORD_W-1:0] cap_word,
    input  logic [SLOT_W-1:0] slot_i,
    input  logic              last_i,
    output logic [LANES-1:0]  ser_data,
    output logic              ser_clk,
    output logic              ser_oe
);

    localparam logic [SLOT_W-1:0] HI_SLOTS =
        SLOT_W'(dlink_ser7_pkg::clk_high_slots(int'(SLOTS)));
    localparam logic [SLOT_W-1:0] ONE_SLOT = SLOT_W'(1);

    typedef struct packed {
        logic [WORD_W-1:0] sync;
        logic [WORD_W-1:0] frame;
        logic [LANES-1:0]  dat;
        logic              clk;
        logic              oe;
    } lanes_t;

    lanes_t st_d, st_q;

    // At the last slot the next frame is the synchronized copy; forward it
    // so that slot 0 of the new frame leaves without a bubble.
    logic [WORD_W-1:0] src_w;
    assign src_w = last_i ? st_q.sync : st_q.frame;

    logic [SLOTS-1:0] lane_src [LANES];
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign lane_src[k] = src_w[k*SLOTS +: SLOTS];
    end

    logic [SLOT_W-1:0] nslot;

    always_comb begin
        nslot      = last_i ? '0 : slot_i + ONE_SLOT;
        st_d       = st_q;
        st_d.sync  = cap_word;
        if (last_i) begin
            st_d.frame = st_q.sync;
        end
        for (int k = 0; k < LANES; k++) begin
            st_d.dat[k] = lane_src[k][nslot];
        end
        st_d.clk = (nslot < HI_SLOTS);
        st_d.oe  = 1'b1;
        if (!pwdn_n) begin
            st_d = '0;
        end
    end

    always_ff @(posedge bit_clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ser_data = st_q.dat;
    assign ser_clk  = st_q.clk;
    assign ser_oe   = st_q.oe;

endmodule

// File: rtl/dlink_ser7.sv
// Top: 7:1 display link serializer with selectable capture edge.
module dlink_ser7 #(
    parameter int unsigned LANES  = dlink_ser7_pkg::DEF_LANES,
    parameter int unsigned SLOTS  = dlink_ser7_pkg::DEF_SLOTS,
    localparam int unsigned WORD_W = LANES * SLOTS,
    localparam int unsigned SLOT_W = $clog2(SLOTS)
) (
    input  logic              pix_clk,
    input  logic              bit_clk,
    input  logic              rst_n,
    input  logic              strobe_rise,
    input  logic              pwdn_n,
    input  logic [WORD_W-1:0] pix_word,
    output logic [LANES-1:0]  ser_data,
    output logic              ser_clk,
    output logic              ser_oe
);

    logic [WORD_W-1:0] cap_w;
    logic [SLOT_W-1:0] slot_w;
    logic              last_w;

    dlink_ser7_capture #(
        .WORD_W (WORD_W)
    ) u_capture (
        .pix_clk     (pix_clk),
        .rst_n       (rst_n),
        .strobe_rise (strobe_rise),
        .pix_word    (pix_word),
        .cap_word    (cap_w)
    );

    dlink_ser7_slot_timer #(
        .SLOTS (SLOTS)
    ) u_timer (
        .bit_clk     (bit_clk),
        .rst_n       (rst_n),
        .pix_clk_smp (pix_clk),
        .slot_o      (slot_w),
        .last_o      (last_w)
    );

    dlink_ser7_lanes #(
        .LANES (LANES),
        .SLOTS (SLOTS)
    ) u_lanes (
        .bit_clk  (bit_clk),
        .rst_n    (rst_n),
        .pwdn_n   (pwdn_n),
        .cap_word (cap_w),
        .slot_i   (slot_w),
        .last_i   (last_w),
        .ser_data (ser_data),
        .ser_clk  (ser_clk),
        .ser_oe   (ser_oe)
    );

endmodule

// File: rtl/dlink_ser7_chk.sv
module dlink_ser7_chk #(
    parameter int unsigned LANES = 4,
    parameter int unsigned SLOTS = 7,
    localparam int unsigned CNT_W = $clog2(SLOTS) + 1
) (
    input logic             bit_clk,
    input logic             rst_n,
    input logic             pwdn_n,
    input logic [LANES-1:0] ser_data,
    input logic             ser_clk,
    input logic             ser_oe,
    input logic             last_i
);

    logic             clk_prev_q;
    logic [CNT_W-1:0] since_q;
    logic [1:0]       rises_q;
    logic             rise_now;

    assign rise_now = ser_clk & ~clk_prev_q;

    // Rising edges of the clock lane since the enable came up; the first one
    // may fall mid-cycle, so period checks start from the second.
    always_ff @(posedge bit_clk or negedge rst_n) begin
        if (!rst_n) begin
            clk_prev_q <= 1'b0;
            since_q    <= '0;
            rises_q    <= '0;
        end else begin
            clk_prev_q <= ser_clk;
            if (!ser_oe) begin
                since_q <= '0;
                rises_q <= '0;
            end else if (rise_now) begin
                since_q <= '0;
                if (rises_q != 2'd2) rises_q <= rises_q + 2'd1;
            end else if (since_q != '1) begin
                since_q <= since_q + CNT_W'(1);
            end
        end
    end

    AST_OE_DROPS: assert property (@(posedge bit_clk) disable iff (!rst_n)
        !pwdn_n |=> !ser_oe); // R5

    AST_LANES_QUIET: assert property (@(posedge bit_clk) disable iff (!rst_n)
        !ser_oe |-> (ser_data == '0 && !ser_clk)); // R6

    AST_OE_RETURNS: assert property (@(posedge bit_clk) disable iff (!rst_n)
        pwdn_n |=> ser_oe); // R7

    AST_CLK_PERIOD: assert property (@(posedge bit_clk) disable iff (!rst_n)
        (rise_now && rises_q == 2'd2) |-> since_q == CNT_W'(SLOTS - 1)); // R2

    AST_CLK_AT_BOUNDARY: assert property (@(posedge bit_clk) disable iff (!rst_n)
        (rise_now && rises_q != 2'd0) |-> $past(last_i)); // R2

    always_comb begin
        if (!rst_n) begin
            AST_RESET_QUIET: assert (ser_oe == 1'b0 || $isunknown(ser_oe)); // R8
        end
    end

endmodule

bind dlink_ser7 dlink_ser7_chk #(
    .LANES (LANES),
    .SLOTS (SLOTS)
) u_chk (
    .bit_clk  (bit_clk),
    .rst_n    (rst_n),
    .pwdn_n   (pwdn_n),
    .ser_data (ser_data),
    .ser_clk  (ser_clk),
    .ser_oe   (ser_oe),
    .last_i   (last_w)
);

// File: tb/tb_dlink_ser7.sv
`timescale 1ns/1ps
module tb_dlink_ser7;

    localparam int LANES = 4;
    localparam int SLOTS = 7;
    localparam int WORD_W = 28;
    localparam logic [6:0] CLK_EXP = 7'b0001111; // slots 0..3 high (R2)
    localparam int LAST_CYC = 160;

    logic              bit_clk = 1'b0;
    logic              pix_clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              strobe_rise = 1'b0;
    logic              pwdn_n = 1'b1;
    logic [WORD_W-1:0] pix_word = '0;
    logic [LANES-1:0]  ser_data;
    logic              ser_clk;
    logic              ser_oe;

    int ph = 0;
    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    logic [WORD_W-1:0] whist [8];
    logic              shist [8];
    logic [WORD_W-1:0] got;
    logic [6:0]        gclk;

    dlink_ser7 dut (
        .pix_clk     (pix_clk),
        .bit_clk     (bit_clk),
        .rst_n       (rst_n),
        .strobe_rise (strobe_rise),
        .pwdn_n      (pwdn_n),
        .pix_word    (pix_word),
        .ser_data    (ser_data),
        .ser_clk     (ser_clk),
        .ser_oe      (ser_oe)
    );

    // 200 MHz bit clock
    initial forever #2.5 bit_clk = ~bit_clk;

    // Pixel clock at 1/7 rate, rising together with a bit clock edge.
    always @(posedge bit_clk) begin
        ph      <= (ph == 6) ? 0 : ph + 1;
        pix_clk <= (ph == 6) || (ph < 3);
    end

    task automatic chk(input bit ok, input string req, input logic [WORD_W-1:0] act,
                       input logic [WORD_W-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    function automatic logic [WORD_W-1:0] pick_word(input int n);
        case (n)
            5:  return 28'h0204081;  // first slot of each lane
            6:  return 28'h8102040;  // last slot of each lane
            7:  return 28'hFFFFFFF;
            8:  return 28'h0000000;
            9:  return 28'h5555555;
            10: return 28'hAAAAAAA;
            11: return 28'h000007F;  // lane 0 only
            12: return 28'hFE00000;  // lane 3 only
            default: return WORD_W'($urandom());
        endcase
    endfunction

    // Word due in cycle n: mode of cycle n-1 picks the falling (n-1) or
    // rising (n-2) capture.
    function automatic logic [WORD_W-1:0] expect_word(input int n);
        return shist[(n - 1) & 7] ? whist[(n - 2) & 7] : whist[(n - 1) & 7];
    endfunction

    initial begin
        int cyc;
        int chg_age;
        bit released;
        logic [WORD_W-1:0] w;
        cyc = 0;
        chg_age = 100;
        released = 1'b0;
        void'($urandom(32'h0000_5EED));
        for (int i = 0; i < 8; i++) begin
            whist[i] = '0;
            shist[i] = 1'b0;
        end

        // R8: reset state
        repeat (3) @(negedge bit_clk);
        chk(ser_oe == 1'b0, "R8 oe", 28'(ser_oe), 28'h0);
        chk(ser_data == '0, "R8 data", 28'(ser_data), 28'h0);
        chk(ser_clk == 1'b0, "R8 clk", 28'(ser_clk), 28'h0);

        while (!(cyc == LAST_CYC && ph == 6)) begin
            @(negedge bit_clk);
            chg_age++;
            if (ph == 0) cyc++;

            for (int k = 0; k < LANES; k++) got[k*SLOTS + ph] = ser_data[k];
            gclk[ph] = ser_clk;

            if (rst_n && chg_age >= 1) begin
                if (!pwdn_n) begin
                    chk(ser_oe == 1'b0, "R5 oe", 28'(ser_oe), 28'h0);
                    chk(ser_data == '0 && ser_clk == 1'b0, "R6 lanes",
                        {23'h0, ser_clk, ser_data}, 28'h0);
                end else if (released && chg_age == 1) begin
                    chk(ser_oe == 1'b1, "R7 oe", 28'(ser_oe), 28'h1);
                end
            end

            if (ph == 6 && cyc >= 5 && !(cyc >= 91 && cyc <= 100)) begin
                string tag;
                if (cyc <= 13)        tag = "R1 word";
                else if (cyc == 101)  tag = "R7 word";
                else if (shist[(cyc - 1) & 7]) tag = "R3 word";
                else                  tag = "R4 word";
                chk(got == expect_word(cyc), tag, got, expect_word(cyc));
                chk(gclk == CLK_EXP, "R2 clock lane", 28'(gclk), 28'(CLK_EXP));
            end

            if (ph == 0) begin
                if (cyc == 2)   rst_n = 1'b1;
                if (cyc == 41)  strobe_rise = 1'b1;
                if (cyc == 120) strobe_rise = 1'b0;
                if (cyc == 91) begin
                    pwdn_n = 1'b0;
                    chg_age = 0;
                end
                shist[cyc & 7] = strobe_rise;
                w = pick_word(cyc);
                whist[cyc & 7] = w;
                pix_word = w;
            end
            if (cyc == 100 && ph == 2) begin
                pwdn_n = 1'b1;
                released = 1'b1;
                chg_age = 0;
            end
        end

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog (all requirements) actual running expected finished");
            summary();
            $finish;
        end
    end

endmodule